// File: doc/BRIEF.md
# Handshaked Byte-Transfer Shift Port

This block moves bytes between a host and a small peripheral controller. It does not use a serial shift clock. Three active-low handshake lines in an eight-bit port register pace each transfer. The host drives two of them: in-progress (bit 5) and acknowledge (bit 4). The device drives request (bit 3). The host writes the port register, the shift register and a control register through a simple select/strobe interface. The block reacts to every write of the port register.

In the host-to-device direction, each handshake edge stores the current shift-register byte into an outbound packet buffer. When in-progress is released, the packet is handed on with a one-cycle strobe. In the device-to-host direction, an inbound packet is loaded in one cycle. Each handshake edge then plays the next byte of that packet into the shift register. Request tells the host when data is waiting and when the packet has ended. A shift interrupt flag marks every byte event, and the host clears it by reading the shift register.

Top module: `hs_shift_port`

## Requirements
- R1: After reset the port register, shift register, control register, shift flag and packet strobe are all zero, and both buffers are empty.
- R2: Control bit 4 selects the direction: 1 is host-to-device, 0 is device-to-host. Consider a port write with in-progress (bit 5) low, in host-to-device direction, where the pair {bit 5, bit 4} differs from the previous port value. That write stores the shift register into the next outbound slot and sets the shift flag.
- R3: The outbound buffer holds at most DEPTH (16) bytes. Edges beyond that store nothing and leave the shift flag untouched.
- R4: Consider a port write with bit 5 low, in device-to-host direction, where the pair changes. While inbound bytes remain, that write loads the next inbound byte into the shift register and sets the shift flag. When it consumes the last byte, request (bit 3) is forced to 1. With no bytes left, the write only stores the port value.
- R5: Consider a port write with bit 5 high where the previous port value also had bit 5 high and bit 4 changed. That write sets bit 3 to the new bit 4 level and sets the shift flag.
- R6: A port write that takes bit 5 from low to high always sets the shift flag. If at least one outbound byte was stored, it also does the following:
  - it pulses pkt_done for one cycle;
  - it presents the byte count on pkt_len and the bytes on pkt_bytes, with byte 0 in bits 7:0;
  - it empties the outbound buffer.
- R7: When a port write leaves bit 5 high (and R5 does not apply) while inbound bytes remain unread, bit 3 is driven to 0.
- R8: A shift-register read (rd_shift) clears the shift flag, unless a flag-setting event occurs in the same cycle.
- R9: A load (load_en) takes load_len bytes, up to DEPTH, from load_bytes (byte 0 in bits 7:0). It resets the read position to zero and sets the shift flag. If the port has bit 5 high and load_len is nonzero, it also drives bit 3 to 0. A port write in the same cycle is ignored.
- R10: Port write bits that the rules above do not change are stored as written. Without a port write or load, the port register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 port, 1 shift, 2 control, 3 none |
| wr_data | input | 8 | Write data |
| rd_shift | input | 1 | Shift-register read strobe |
| load_en | input | 1 | Load an inbound packet |
| load_len | input | CW | Inbound byte count |
| load_bytes | input | 8*DEPTH | Inbound packet bytes |
| port_q | output | 8 | Port register |
| shift_q | output | 8 | Shift register |
| shift_flag | output | 1 | Shift interrupt flag |
| pkt_done | output | 1 | Outbound packet complete strobe |
| pkt_len | output | CW | Completed packet byte count |
| pkt_bytes | output | 8*DEPTH | Outbound buffer contents |

## Verification
The bound assertions check the following on every cycle:
- the outbound count never exceeds the buffer depth;
- pkt_done fires only on an in-progress rising write and carries a nonzero length;
- a quiet read clears the flag;
- a load sets the flag;
- the port register is stable when nothing touches it.

Only the bench scenarios can show the following: the byte order in both directions, the end-of-packet request release, request following acknowledge between packets, and the dropping of bytes past the sixteenth.

// File: rtl/hs_shift_port.sv
module hs_shift_port #(
  parameter int DEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [1:0]                wr_sel,
  input  logic [7:0]                wr_data,
  input  logic                      rd_shift,
  input  logic                      load_en,
  input  logic [$clog2(DEPTH+1)-1:0] load_len,
  input  logic [8*DEPTH-1:0]        load_bytes,
  output logic [7:0]                port_q,
  output logic [7:0]                shift_q,
  output logic                      shift_flag,
  output logic                      pkt_done,
  output logic [$clog2(DEPTH+1)-1:0] pkt_len,
  output logic [8*DEPTH-1:0]        pkt_bytes
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int AW = $clog2(DEPTH);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [7:0]                ctrl_q;
  logic [DEPTH-1:0][7:0]     out_buf;
  logic [DEPTH-1:0][7:0]     in_buf;
  logic [CW-1:0]             out_cnt, in_idx, in_len;

  logic port_wr, dir_out, pair_chg, in_left;
  logic store_out, take_in, flag_set, fire;
  logic [7:0] nport;

  assign port_wr  = wr_en && (wr_sel == 2'd0) && !load_en;
  assign dir_out  = ctrl_q[4];
  assign pair_chg = wr_data[5:4] != port_q[5:4];
  assign in_left  = in_idx < in_len;
  assign pkt_bytes = out_buf;

  always_comb begin
    nport     = wr_data;
    store_out = 1'b0;
    take_in   = 1'b0;
    flag_set  = 1'b0;
    fire      = 1'b0;
    if (!wr_data[5]) begin
      if (dir_out) begin
        if (pair_chg && out_cnt < FULL) begin
          store_out = 1'b1;
          flag_set  = 1'b1;
        end
      end else if (pair_chg && in_left) begin
        take_in  = 1'b1;
        flag_set = 1'b1;
        if (in_idx + 1'b1 >= in_len) nport[3] = 1'b1;
      end
    end else if (port_q[5] && (wr_data[4] != port_q[4])) begin
      nport[3] = wr_data[4];
      flag_set = 1'b1;
    end else begin
      if (!port_q[5]) begin
        flag_set = 1'b1;
        fire     = out_cnt != '0;
      end
      if (in_left) nport[3] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_q     <= '0;
      shift_q    <= '0;
      ctrl_q     <= '0;
      shift_flag <= 1'b0;
      pkt_done   <= 1'b0;
      pkt_len    <= '0;
      out_cnt    <= '0;
      in_idx     <= '0;
      in_len     <= '0;
      out_buf    <= '0;
      in_buf     <= '0;
    end else begin
      pkt_done <= 1'b0;
      if (rd_shift) shift_flag <= 1'b0;
      if (load_en) begin
        in_buf     <= load_bytes;
        in_len     <= load_len;
        in_idx     <= '0;
        shift_flag <= 1'b1;
        if (port_q[5] && load_len != '0) port_q[3] <= 1'b0;
      end else if (port_wr) begin
        port_q <= nport;
        if (flag_set) shift_flag <= 1'b1;
        if (store_out) begin
          out_buf[out_cnt[AW-1:0]] <= shift_q;
          out_cnt <= out_cnt + 1'b1;
        end
        if (take_in) begin
          shift_q <= in_buf[in_idx[AW-1:0]];
          in_idx  <= in_idx + 1'b1;
        end
        if (fire) begin
          pkt_done <= 1'b1;
          pkt_len  <= out_cnt;
          out_cnt  <= '0;
        end
      end
      if (wr_en && wr_sel == 2'd1 && !load_en) shift_q <= wr_data;
      if (wr_en && wr_sel == 2'd2 && !load_en) ctrl_q  <= wr_data;
    end
  end
endmodule

// File: rtl/hs_shift_port_chk.sv
module hs_shift_port_chk #(
  parameter int CW = 5,
  parameter int DEPTH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_shift,
  input logic          load_en,
  input logic [7:0]    port_q,
  input logic          shift_flag,
  input logic          pkt_done,
  input logic [CW-1:0] pkt_len,
  input logic [CW-1:0] out_cnt
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= CW'(DEPTH));                                           // R3
  AST_DONE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (pkt_len != '0));                                    // R6
  AST_DONE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (port_q[5] && !$past(port_q[5])));                   // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_shift && !wr_en && !load_en) |=> !shift_flag);                // R8
  AST_LOAD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> shift_flag);                                          // R9
  AST_PORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !load_en) |=> $stable(port_q));                        // R10
endmodule

bind hs_shift_port hs_shift_port_chk #(.CW(CW), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_shift(rd_shift),
  .load_en(load_en), .port_q(port_q), .shift_flag(shift_flag),
  .pkt_done(pkt_done), .pkt_len(pkt_len), .out_cnt(out_cnt));

// File: tb/hs_shift_port_tb_top.sv
module hs_shift_port_tb_top;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH+1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_shift = 1'b0, load_en = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [7:0] wr_data = '0;
  logic [CW-1:0] load_len = '0;
  logic [8*DEPTH-1:0] load_bytes = '0;
  logic [7:0] port_q, shift_q;
  logic shift_flag, pkt_done;
  logic [CW-1:0] pkt_len;
  logic [8*DEPTH-1:0] pkt_bytes;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  hs_shift_port #(.DEPTH(DEPTH)) dut_i (.*);

  // op(2) data(8) port(8) flag(1) shift(8) done(1); op 0 port,1 shift,2 ctrl,3 read
  localparam logic [27:0] VEC [16] = '{
    {2'd2, 8'h10, 8'h00, 1'b0, 8'h00, 1'b0},  // R2 direction out
    {2'd0, 8'h38, 8'h38, 1'b1, 8'h00, 1'b0},  // R6 rise, empty
    {2'd3, 8'h00, 8'h38, 1'b0, 8'h00, 1'b0},  // R8
    {2'd1, 8'hA5, 8'h38, 1'b0, 8'hA5, 1'b0},
    {2'd0, 8'h18, 8'h18, 1'b1, 8'hA5, 1'b0},  // R2 store A5
    {2'd3, 8'h00, 8'h18, 1'b0, 8'hA5, 1'b0},
    {2'd1, 8'h3C, 8'h18, 1'b0, 8'h3C, 1'b0},
    {2'd0, 8'h08, 8'h08, 1'b1, 8'h3C, 1'b0},  // R2 store 3C
    {2'd3, 8'h00, 8'h08, 1'b0, 8'h3C, 1'b0},
    {2'd0, 8'h28, 8'h28, 1'b1, 8'h3C, 1'b1},  // R6 done
    {2'd3, 8'h00, 8'h28, 1'b0, 8'h3C, 1'b0},
    {2'd0, 8'h30, 8'h38, 1'b1, 8'h3C, 1'b0},  // R5 req follows ack high
    {2'd3, 8'h00, 8'h38, 1'b0, 8'h3C, 1'b0},
    {2'd0, 8'h28, 8'h20, 1'b1, 8'h3C, 1'b0},  // R5 req follows ack low
    {2'd3, 8'h00, 8'h20, 1'b0, 8'h3C, 1'b0},
    {2'd0, 8'h28, 8'h28, 1'b0, 8'h3C, 1'b0}   // R10 stored as written
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic rd();
    rd_shift = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_shift = 1'b0;
  endtask

  task automatic load(input logic [CW-1:0] n, input logic [8*DEPTH-1:0] b);
    load_en = 1'b1; load_len = n; load_bytes = b;
    @(posedge clk); @(negedge clk);
    load_en = 1'b0;
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {port_q, shift_q, 6'd0, shift_flag, pkt_done}, 24'h0);

    foreach (VEC[i]) begin
      if (VEC[i][27:26] == 2'd3) rd();
      else wr(VEC[i][27:26], VEC[i][25:18]);
      chk($sformatf("vec%0d", i), {port_q, 7'd0, shift_flag, shift_q, 7'd0, pkt_done},
          {VEC[i][17:10], 7'd0, VEC[i][9], VEC[i][8:1], 7'd0, VEC[i][0]});
      if (i == 9) begin
        chk("R6 len", 64'(pkt_len), 64'd2);
        chk("R6 bytes", 64'(pkt_bytes[15:0]), 64'h3CA5);
      end
    end

    wr(2'd2, 8'h00);
    load(CW'(3), {104'd0, 24'h332211});
    chk("R9 load", {port_q, 7'd0, shift_flag}, 16'h2001);
    rd();
    wr(2'd0, 8'h08);
    chk("R4 first", {port_q, shift_q, 7'd0, shift_flag}, 24'h081101);
    rd();
    wr(2'd0, 8'h18);
    chk("R4 second", {port_q, shift_q}, 16'h1822);
    wr(2'd0, 8'h00);
    chk("R4 last forces req", {port_q, shift_q}, 16'h0833);
    rd();
    wr(2'd0, 8'h10);
    chk("R4 exhausted", {port_q, shift_q, 7'd0, shift_flag}, 24'h103300);

    load(CW'(2), {112'd0, 16'h5566});
    chk("R9 tip low keeps req", {port_q, 7'd0, shift_flag}, 16'h1001);
    rd();
    wr(2'd0, 8'h38);
    chk("R7 pending drives req", {port_q, 7'd0, shift_flag}, 16'h3001);

    wr(2'd2, 8'h10);
    wr(2'd0, 8'h30);
    for (int k = 0; k < 18; k++) begin
      wr(2'd1, 8'h40 + 8'(k));
      wr(2'd0, (k % 2 == 0) ? 8'h00 : 8'h10);
    end
    rd();
    wr(2'd0, 8'h10);
    chk("R3 extra ignored", 64'(shift_flag), 64'd0);
    wr(2'd0, 8'h30);
    chk("R3 done", 64'(pkt_done), 64'd1);
    chk("R3 len capped", 64'(pkt_len), 64'd16);
    chk("R3 last kept", 64'(pkt_bytes[127:120]), 64'h4F);
    chk("R3 first kept", 64'(pkt_bytes[7:0]), 64'h40);
    @(negedge clk);
    chk("R6 one cycle", 64'(pkt_done), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule